// File: doc/BRIEF.md
# Static Memory Bus Controller

This block turns single internal transfer requests into cycles on an external asynchronous 16-bit bus. The bus is shared by three regions, each with its own active-low chip select: boot ROM or flash, static RAM, and memory-mapped I/O. A request names its region, its direction, its size (byte or halfword), a 20-bit byte address and, for writes, the data. The block then runs one complete bus cycle. It drives the address, the two byte lane selects, the chip select and the output-enable or write-enable strobe, and it drives write data or captures read data. When the cycle is over it returns a one-cycle acknowledge.

Every region has two 3-bit timing fields, both counted in bus clock cycles. The setup count says how long the chip select, address and byte selects stand before the strobe falls. The strobe count says how long the strobe stays low. After the strobe rises, one more cycle keeps the chip select active, so every transfer holds its chip select for setup + strobe + 1 cycles.

Requests use a valid/ready handshake, and only one transfer can be in flight. The controller raises `req_ready` only while it is idle, and a request transfers on the clock edge where `req_valid` and `req_ready` are both high. A requester that sees `req_ready` low must hold its request stable until it is accepted. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse, and the requester must take `rsp_rdata` in that cycle.

Top module: `smc_top`

## Requirements
- R1: `req_ready` is high exactly when no transfer is active. A request is accepted on the edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance through the acknowledge cycle, and it is high again in the cycle after that.
- R2: Region code 0 selects `ext_cs_n[0]` (ROM), code 1 selects `ext_cs_n[1]` (RAM), and codes 2 and 3 select `ext_cs_n[2]` (I/O). At most one chip select is ever low.
- R3: On a read with effective counts s (setup) and w (strobe), the chip select, address and byte selects are active for s cycles before `ext_oe_n` falls. `ext_oe_n` then stays low for exactly w cycles, and `ext_we_n` stays high.
- R4: On a write, `ext_we_n` falls s cycles after the chip select, address and byte selects become active. It stays low for exactly w cycles, and `ext_oe_n` stays high.
- R5: After the strobe rises, the chip select stays low for exactly one more cycle, so the chip select is active for s + w + 1 cycles in total. It then returns high.
- R6: On a write, `ext_dout_en` is high from the cycle `ext_we_n` falls through the cycle after it rises. While it is high, `ext_dout` carries the write data: the halfword as given, or for a byte write the low data byte copied onto both lanes. `ext_dout_en` is low at all other times.
- R7: On a read, `ext_din` is sampled on the last cycle of the output-enable pulse. `rsp_valid` is high for exactly one cycle, the cycle after the strobe ends (for writes too). In that cycle `rsp_rdata` is the full bus for a halfword read. For a byte read it is the selected lane in bits [7:0], with bits [15:8] zero.
- R8: A timing field programmed as 0 behaves as 1.
- R9: The byte selects are active low, with bit 0 for the low lane (bits 7:0) and bit 1 for the high lane. A halfword access drives `2'b00`. A byte access with address bit 0 clear drives `2'b10`, and one with address bit 0 set drives `2'b01`. Both bits are high while idle.
- R10: Timing fields are sampled when a request is accepted. Changing `cfg_setup` or `cfg_strobe` during a transfer has no effect on it.
- R11: While the chip select is active, `ext_addr` equals `req_addr[19:1]` of the accepted request and stays constant.
- R12: The region for region r takes its setup field from `cfg_setup[3r+2:3r]` and its strobe field from `cfg_strobe[3r+2:3r]`. Code 3 uses the I/O fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | 2 | Region code (0 ROM, 1 RAM, 2/3 I/O) |
| req_half | input | 1 | 1 = halfword, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle acknowledge |
| rsp_rdata | output | 16 | Read data, lane-aligned |
| cfg_setup | input | 9 | Setup counts, 3 bits per region |
| cfg_strobe | input | 9 | Strobe widths, 3 bits per region |
| ext_addr | output | 19 | External address bits [19:1] |
| ext_be_n | output | 2 | Active-low byte lane selects |
| ext_cs_n | output | 3 | Active-low chip selects (ROM, RAM, I/O) |
| ext_oe_n | output | 1 | Active-low output enable |
| ext_we_n | output | 1 | Active-low write enable |
| ext_dout | output | 16 | Write data to the bus |
| ext_dout_en | output | 1 | Write data drive enable |
| ext_din | input | 16 | Read data from the bus |

## Verification
Count k from the edge that accepts a request. Then cycle k = 1 .. s is setup, cycles s+1 .. s+w are strobe, and cycle s+w+1 is the hold cycle, which carries `rsp_valid` and the captured read data. `req_ready` comes back at k = s+w+2. The bench computes s, w and every pin value for each k from the request alone, and samples on the falling edge after each rising edge, so each check sees exactly the cycle k it models. Directed cases cover zero fields, the longest windows, every byte lane and a reprogramming in the middle of a transfer.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int DW   = 16;
  localparam int NREG = 3;
  localparam int CW   = 3;
  localparam int RW   = 2;
  localparam int AW   = 20;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;
endpackage

// File: rtl/smc_timing_sel.sv
module smc_timing_sel #(
  parameter int NREG = 3,
  parameter int CW   = 3,
  parameter int RW   = 2
) (
  input  logic [NREG*CW-1:0] cfg_setup,
  input  logic [NREG*CW-1:0] cfg_strobe,
  input  logic [RW-1:0]      region_idx,
  output logic [CW-1:0]      setup_eff,
  output logic [CW-1:0]      strobe_eff
);
  logic [CW-1:0] su_arr [NREG];
  logic [CW-1:0] st_arr [NREG];

  // a programmed zero is clamped to one cycle (R8)
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign su_arr[g] = (cfg_setup[g*CW +: CW] == '0)  ? CW'(1) : cfg_setup[g*CW +: CW];
    assign st_arr[g] = (cfg_strobe[g*CW +: CW] == '0) ? CW'(1) : cfg_strobe[g*CW +: CW];
  end

  assign setup_eff  = su_arr[region_idx];
  assign strobe_eff = st_arr[region_idx];
endmodule

// File: rtl/smc_lane_dec.sv
module smc_lane_dec #(
  parameter int DW = 16
) (
  input  logic          half,
  input  logic          a0,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] bus_in,
  output logic [1:0]    be_n,
  output logic [DW-1:0] wlane,
  output logic [DW-1:0] rd_align
);
  localparam int BW = DW / 2;

  always_comb begin
    if (half)    be_n = 2'b00;
    else if (a0) be_n = 2'b01;
    else         be_n = 2'b10;
  end

  assign wlane = half ? wdata : {wdata[BW-1:0], wdata[BW-1:0]};

  always_comb begin
    if (half)    rd_align = bus_in;
    else if (a0) rd_align = {{BW{1'b0}}, bus_in[DW-1:BW]};
    else         rd_align = {{BW{1'b0}}, bus_in[BW-1:0]};
  end
endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] setup_cnt,
  input  logic [CW-1:0] strobe_cnt,
  output logic          ph_idle,
  output logic          ph_setup,
  output logic          ph_strobe,
  output logic          ph_hold,
  output logic          strobe_last
);
  phase_e        st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PH_IDLE;
      cnt      <= '0;
      strobe_q <= '0;
    end else begin
      case (st)
        PH_IDLE: if (start) begin
          st       <= PH_SETUP;
          cnt      <= setup_cnt - CW'(1);
          strobe_q <= strobe_cnt;
        end
        PH_SETUP: if (cnt == '0) begin
          st  <= PH_STROBE;
          cnt <= strobe_q - CW'(1);
        end else begin
          cnt <= cnt - CW'(1);
        end
        PH_STROBE: if (cnt == '0) st <= PH_HOLD;
                   else cnt <= cnt - CW'(1);
        default: st <= PH_IDLE;
      endcase
    end
  end

  assign ph_idle     = (st == PH_IDLE);
  assign ph_setup    = (st == PH_SETUP);
  assign ph_strobe   = (st == PH_STROBE);
  assign ph_hold     = (st == PH_HOLD);
  assign strobe_last = ph_strobe && (cnt == '0);

  AST_HOLD_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ph_hold |-> $past(ph_strobe)); // R5
  AST_SETUP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_setup) |-> $past(ph_idle && start)); // R1
endmodule

// File: rtl/smc_top.sv
module smc_top
  import smc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [RW-1:0]       req_region,
  input  logic                req_half,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_rdata,
  input  logic [NREG*CW-1:0]  cfg_setup,
  input  logic [NREG*CW-1:0]  cfg_strobe,
  output logic [AW-1:1]       ext_addr,
  output logic [1:0]          ext_be_n,
  output logic [NREG-1:0]     ext_cs_n,
  output logic                ext_oe_n,
  output logic                ext_we_n,
  output logic [DW-1:0]       ext_dout,
  output logic                ext_dout_en,
  input  logic [DW-1:0]       ext_din
);
  localparam int LAST = NREG - 1;

  logic          accept;
  logic [RW-1:0] in_idx;
  logic [CW-1:0] setup_eff, strobe_eff;
  logic          ph_idle, ph_setup, ph_strobe, ph_hold, strobe_last;

  logic          q_write, q_half;
  logic [RW-1:0] q_idx;
  logic [AW-1:0] q_addr;
  logic [DW-1:0] q_wdata;
  logic [1:0]    dec_be_n;
  logic [DW-1:0] dec_wlane, dec_rd;

  assign req_ready = ph_idle;
  assign accept    = req_valid && ph_idle;
  assign in_idx    = (req_region > RW'(LAST)) ? RW'(LAST) : req_region;

  smc_timing_sel #(.NREG(NREG), .CW(CW), .RW(RW)) u_tsel (
    .cfg_setup  (cfg_setup),
    .cfg_strobe (cfg_strobe),
    .region_idx (in_idx),
    .setup_eff  (setup_eff),
    .strobe_eff (strobe_eff)
  );

  smc_seq #(.CW(CW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .setup_cnt   (setup_eff),
    .strobe_cnt  (strobe_eff),
    .ph_idle     (ph_idle),
    .ph_setup    (ph_setup),
    .ph_strobe   (ph_strobe),
    .ph_hold     (ph_hold),
    .strobe_last (strobe_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_write <= 1'b0;
      q_half  <= 1'b0;
      q_idx   <= '0;
      q_addr  <= '0;
      q_wdata <= '0;
    end else if (accept) begin
      q_write <= req_write;
      q_half  <= req_half;
      q_idx   <= in_idx;
      q_addr  <= req_addr;
      q_wdata <= req_wdata;
    end
  end

  smc_lane_dec #(.DW(DW)) u_lane (
    .half     (q_half),
    .a0       (q_addr[0]),
    .wdata    (q_wdata),
    .bus_in   (ext_din),
    .be_n     (dec_be_n),
    .wlane    (dec_wlane),
    .rd_align (dec_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rsp_rdata <= '0;
    else if (strobe_last && !q_write) rsp_rdata <= dec_rd;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_cs
    assign ext_cs_n[g] = ph_idle || (q_idx != RW'(g));
  end

  assign ext_addr    = q_addr[AW-1:1];
  assign ext_be_n    = ph_idle ? 2'b11 : dec_be_n;
  assign ext_oe_n    = !(ph_strobe && !q_write);
  assign ext_we_n    = !(ph_strobe && q_write);
  assign ext_dout_en = q_write && (ph_strobe || ph_hold);
  assign ext_dout    = dec_wlane;
  assign rsp_valid   = ph_hold;

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_cs_n)); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_oe_n && !ext_we_n)); // R3
  AST_CS_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ext_oe_n) || $rose(ext_we_n)) |-> (ext_cs_n != {NREG{1'b1}})); // R5
  AST_WDATA_UNDER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_we_n |-> ext_dout_en); // R6
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_we_n) |-> ext_dout_en); // R6
  AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!ext_oe_n) || $past(!ext_we_n))); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cs_n != {NREG{1'b1}}) |-> !req_ready); // R1
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_cs_n != {NREG{1'b1}}) && ($past(ext_cs_n) != {NREG{1'b1}}))
      |-> ($stable(ext_addr) && $stable(ext_be_n))); // R11
endmodule

// File: tb/smc_top_tb.sv
module smc_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_region = '0;
  logic        req_half = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [8:0]  cfg_setup = '0;
  logic [8:0]  cfg_strobe = '0;
  logic [19:1] ext_addr;
  logic [1:0]  ext_be_n;
  logic [2:0]  ext_cs_n;
  logic        ext_oe_n, ext_we_n, ext_dout_en;
  logic [15:0] ext_dout;
  logic [15:0] ext_din = '0;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  smc_top u_dut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int eff(input logic [2:0] v);
    return (v == 3'd0) ? 1 : int'(v);
  endfunction

  function automatic logic [2:0] exp_cs(input logic [1:0] r);
    return (r == 2'd0) ? 3'b110 : (r == 2'd1) ? 3'b101 : 3'b011;
  endfunction

  function automatic logic [1:0] exp_be(input logic h, input logic a0);
    return h ? 2'b00 : (a0 ? 2'b01 : 2'b10);
  endfunction

  function automatic logic [15:0] exp_rd(input logic h, input logic a0, input logic [15:0] d);
    return h ? d : (a0 ? {8'h00, d[15:8]} : {8'h00, d[7:0]});
  endfunction

  function automatic logic [15:0] exp_wd(input logic h, input logic [15:0] d);
    return h ? d : {d[7:0], d[7:0]};
  endfunction

  // one transfer; optionally reprogram timing right after acceptance (R10)
  task automatic xfer(input logic wr, input logic [1:0] rg, input logic h,
                      input logic [19:0] a, input logic [15:0] wd, input logic [15:0] din,
                      input bit scramble);
    int s, w, t, ri;
    ri = (rg == 2'd3) ? 2 : int'(rg);
    s = eff(cfg_setup[ri*3 +: 3]);   // R12
    w = eff(cfg_strobe[ri*3 +: 3]);  // R8
    t = s + w + 1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_region = rg; req_half = h;
    req_addr = a; req_wdata = wd; ext_din = din;
    chk("R1", "ready idle", 32'(req_ready), 32'd1);
    for (int k = 1; k <= t + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        req_valid = 1'b0;
        req_addr = ~a; req_wdata = ~wd;
        if (scramble) begin cfg_setup = ~cfg_setup; cfg_strobe = ~cfg_strobe; end
      end
      chk("R1", "ready", 32'(req_ready), 32'(k > t));
      chk("R5", "cs_n", 32'(ext_cs_n), (k <= t) ? 32'(exp_cs(rg)) : 32'h7);
      chk("R9", "be_n", 32'(ext_be_n), (k <= t) ? 32'(exp_be(h, a[0])) : 32'h3);
      if (k <= t) chk("R11", "addr", 32'(ext_addr), 32'(a[19:1]));
      chk(wr ? "R4" : "R3", "oe_n", 32'(ext_oe_n), 32'(!(!wr && k > s && k <= s + w)));
      chk(wr ? "R4" : "R3", "we_n", 32'(ext_we_n), 32'(!(wr && k > s && k <= s + w)));
      chk("R6", "dout_en", 32'(ext_dout_en), 32'(wr && k > s && k <= t));
      if (ext_dout_en) chk("R6", "dout", 32'(ext_dout), 32'(exp_wd(h, wd)));
      chk("R7", "rsp_valid", 32'(rsp_valid), 32'(k == t));
      if (k == t && !wr) chk("R7", "rdata", 32'(rsp_rdata), 32'(exp_rd(h, a[0], din)));
    end
    if (scramble) begin cfg_setup = ~cfg_setup; cfg_strobe = ~cfg_strobe; end
  endtask

  initial begin
    void'($urandom(32'h1D5E));
    repeat (3) @(negedge clk);
    chk("R1", "reset ready", 32'(req_ready), 32'd1);
    chk("R2", "reset cs_n", 32'(ext_cs_n), 32'h7);
    chk("R7", "reset rsp", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    // R8: all fields zero -> 1/1
    cfg_setup = 9'o000; cfg_strobe = 9'o000;
    xfer(1'b0, 2'd0, 1'b1, 20'h12344, 16'h0, 16'hBEEF, 1'b0);
    xfer(1'b1, 2'd1, 1'b1, 20'h00010, 16'hCAFE, 16'h0, 1'b0);
    // R12: distinct fields per region, longest windows
    cfg_setup = 9'o731; cfg_strobe = 9'o257;
    xfer(1'b0, 2'd0, 1'b0, 20'hABCD0, 16'h0, 16'h5AA5, 1'b0); // R9 low lane
    xfer(1'b0, 2'd1, 1'b0, 20'hABCD1, 16'h0, 16'h5AA5, 1'b0); // R9 high lane
    xfer(1'b1, 2'd2, 1'b0, 20'h00003, 16'h7781, 16'h0, 1'b0);
    xfer(1'b1, 2'd3, 1'b1, 20'hFFFFE, 16'h1234, 16'h0, 1'b0); // R2 code 3
    cfg_setup = 9'o777; cfg_strobe = 9'o777;
    xfer(1'b0, 2'd2, 1'b1, 20'h55554, 16'h0, 16'hF00F, 1'b0);
    // R10: reprogram mid-transfer
    cfg_setup = 9'o123; cfg_strobe = 9'o456;
    xfer(1'b1, 2'd1, 1'b0, 20'h0F0F0, 16'h00A5, 16'h0, 1'b1);
    xfer(1'b0, 2'd2, 1'b0, 20'h0F0F1, 16'h0, 16'h9C3E, 1'b1);
    for (int i = 0; i < 60; i++) begin
      cfg_setup = 9'($urandom); cfg_strobe = 9'($urandom);
      xfer(1'($urandom), 2'($urandom), 1'($urandom), 20'($urandom),
           16'($urandom), 16'($urandom), 1'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule